// File: doc/BRIEF.md
# Home-Node Sharer Directory with Software Overflow

This block is the coherence directory for a single home memory node. For every memory block it owns, it records the block's sharing state and a small hardware list of sharer node IDs. Remote nodes send read and write requests. The block grants shared or exclusive copies. When a writer needs exclusive access, it first sends invalidations to the other sharers and collects their acknowledgements. When a reader finds a dirty owner, it recalls the owner's copy first.

The hardware sharer list has a fixed capacity (`NUM_PTRS`). A read that would need one more slot than the list holds is not recorded. Instead the controller marks the entry as overflowed and hands the request to a software handler on the local processor through a trap handshake. That handler then keeps the sharer list in local memory. While the overflow mark is set, every request for that block is handed to software. The handler ends a trap with `trap_done`. If it also asserts `trap_release`, the entry returns to hardware control as an invalid block. Building the block with `NUM_PTRS = 0` gives a purely software directory: every request traps.

Only one transaction is open at a time. A request that arrives while the engine is busy gets a retry on a separate port. It is not queued and has no effect on the directory.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every entry is invalid with no overflow mark. `rsp_valid`, `nack_valid`, `inv_valid` and `trap_valid` are all low.
- R2: A read by a node not yet listed, to an invalid block or to a read-clean block with a free slot, gets a shared grant (`rsp_excl`=0) in the cycle after acceptance. The node is appended to the sharer list in arrival order.
- R3: A read that would need one slot more than `NUM_PTRS` gives no grant. It sets the entry's overflow mark and raises `trap_valid` in the cycle after acceptance. `trap_addr`, `trap_node` and `trap_write` (1 = write) hold steady until the cycle `trap_done` is sampled. `trap_valid` is low the cycle after that.
- R4: While an entry's overflow mark is set, every read or write to it traps and gets no grant. A `trap_done` together with `trap_release` clears the mark and makes the block invalid with an empty list.
- R5: With `NUM_PTRS` = 0, every request traps and no grant is ever issued.
- R6: A write to a read-clean block sends one invalidation (`inv_fetch`=0) per cycle to each listed sharer other than the writer, lowest slot first. The exclusive grant (`rsp_excl`=1) comes the cycle after the last acknowledgement and never earlier.
- R7: A request by another node to a write-dirty block sends one recall (`inv_fetch`=1) to the owner. After its acknowledgement, a read gets a shared grant and the list becomes {old owner, requester} in that order. A write gets an exclusive grant and becomes the sole owner.
- R8: A request accepted while a transaction or trap is open gets `nack_valid` with its node ID the next cycle. It changes no directory state.
- R9: A write to an invalid block, a request by the current dirty owner, a read by a node already listed, and a write by the only listed sharer are all granted the next cycle without any invalidation and without using a new slot.
- R10: A `trap_done` without `trap_release` leaves the overflow mark set, so the next request to that block traps again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write (exclusive), 0 = read |
| req_addr | input | ADDR_W | Block index |
| req_node | input | NODE_W | Requesting node ID |
| rsp_valid | output | 1 | Grant pulse |
| rsp_excl | output | 1 | 1 = exclusive grant, 0 = shared grant |
| rsp_node | output | NODE_W | Node receiving the grant |
| nack_valid | output | 1 | Retry pulse for a request refused while busy |
| nack_node | output | NODE_W | Node told to retry |
| inv_valid | output | 1 | Invalidation or recall sent this cycle |
| inv_fetch | output | 1 | 1 = recall from dirty owner, 0 = invalidate sharer |
| inv_addr | output | ADDR_W | Block being invalidated |
| inv_node | output | NODE_W | Target node |
| ack_valid | input | 1 | One acknowledgement for an outstanding invalidation |
| trap_valid | output | 1 | Software trap pending |
| trap_write | output | 1 | Request type of the trapped request |
| trap_addr | output | ADDR_W | Block of the trapped request |
| trap_node | output | NODE_W | Requester of the trapped request |
| trap_done | input | 1 | Handler finished |
| trap_release | input | 1 | With trap_done: clear overflow, make block invalid |

## Verification
The bench drives the block to the capacity boundary. It checks that the fourth distinct reader is still granted, that a repeated reader is absorbed without trapping, and that the next new reader traps. A design with an off-by-one slot count would grant a fifth sharer or trap one reader early. A design that compared IDs wrongly would trap on a repeat reader. The bench then holds acknowledgements back to catch an exclusive grant given before the last acknowledgement. It checks that the writer never receives its own invalidation. It recalls a dirty owner and writes again to prove both the owner and the reader were recorded; an engine that dropped the old owner would miss an invalidation. It probes the retry port during open transactions and traps, checks that a trap finished without release leaves the block trapping, and drives a zero-slot instance that must never grant.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    BLK_INV = 2'd0,
    BLK_RC  = 2'd1,
    BLK_WD  = 2'd2
  } blk_state_e;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_SEND = 2'd1,
    ENG_WAIT = 2'd2,
    ENG_TRAP = 2'd3
  } eng_state_e;
endpackage

// File: rtl/dir_rst_sync.sv
module dir_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dir_entry_store.sv
module dir_entry_store
  import dir_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int ADDR_W     = 3,
  parameter int NODE_W     = 3,
  parameter int SLOTS      = 4,
  parameter int CNT_W      = 3,
  parameter int NUM_PTRS   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             rd_addr,
  output blk_state_e                    rd_state,
  output logic                          rd_ovf,
  output logic [CNT_W-1:0]              rd_cnt,
  output logic [SLOTS-1:0][NODE_W-1:0]  rd_ptrs,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  blk_state_e                    wr_state,
  input  logic                          wr_ovf,
  input  logic [CNT_W-1:0]              wr_cnt,
  input  logic [SLOTS-1:0][NODE_W-1:0]  wr_ptrs
);
  blk_state_e                   state_q [NUM_BLOCKS];
  logic                         ovf_q   [NUM_BLOCKS];
  logic [CNT_W-1:0]             cnt_q   [NUM_BLOCKS];
  logic [SLOTS-1:0][NODE_W-1:0] ptr_q   [NUM_BLOCKS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BLOCKS; b++) begin
        state_q[b] <= BLK_INV;
        ovf_q[b]   <= 1'b0;
        cnt_q[b]   <= '0;
      end
    end else if (wr_en) begin
      state_q[wr_addr] <= wr_state;
      ovf_q[wr_addr]   <= wr_ovf;
      cnt_q[wr_addr]   <= wr_cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) ptr_q[wr_addr] <= wr_ptrs;
  end

  assign rd_state = state_q[rd_addr];
  assign rd_ovf   = ovf_q[rd_addr];
  assign rd_cnt   = cnt_q[rd_addr];
  assign rd_ptrs  = ptr_q[rd_addr];

  // The hardware list never records more sharers than it has slots.
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_cnt <= CNT_W'(NUM_PTRS)))
    else $error("sharer count written above capacity");

  // A read-clean entry always names at least one sharer.
  assert_rc_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_state == BLK_RC) |-> (wr_cnt != '0))
    else $error("read-clean entry written with no sharer");
endmodule

// File: rtl/dir_sharer_match.sv
module dir_sharer_match #(
  parameter int NODE_W = 3,
  parameter int SLOTS  = 4,
  parameter int CNT_W  = 3
) (
  input  logic [SLOTS-1:0][NODE_W-1:0] ptrs,
  input  logic [CNT_W-1:0]             cnt,
  input  logic [NODE_W-1:0]            node,
  output logic                         hit,
  output logic [SLOTS-1:0]             others_mask
);
  logic [SLOTS-1:0] match;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic live;
    assign live           = (CNT_W'(s) < cnt);
    assign match[s]       = live && (ptrs[s] == node);
    assign others_mask[s] = live && (ptrs[s] != node);
  end

  assign hit = |match;
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int NODE_W     = 3,
  parameter int NUM_PTRS   = 4,
  localparam int ADDR_W    = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [NODE_W-1:0] req_node,
  output logic              rsp_valid,
  output logic              rsp_excl,
  output logic [NODE_W-1:0] rsp_node,
  output logic              nack_valid,
  output logic [NODE_W-1:0] nack_node,
  output logic              inv_valid,
  output logic              inv_fetch,
  output logic [ADDR_W-1:0] inv_addr,
  output logic [NODE_W-1:0] inv_node,
  input  logic              ack_valid,
  output logic              trap_valid,
  output logic              trap_write,
  output logic [ADDR_W-1:0] trap_addr,
  output logic [NODE_W-1:0] trap_node,
  input  logic              trap_done,
  input  logic              trap_release
);
  localparam bit ZERO_MODE = (NUM_PTRS == 0);
  localparam int SLOTS     = ZERO_MODE ? 2 : NUM_PTRS;
  localparam int CNT_W     = $clog2(SLOTS + 1);
  localparam int SEL_W     = $clog2(SLOTS);

  typedef logic [SLOTS-1:0][NODE_W-1:0] ptr_vec_t;

  logic rst_sync_n;
  dir_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  // Entry storage and lookup
  logic [ADDR_W-1:0] rd_addr;
  blk_state_e        rd_state, wr_state;
  logic              rd_ovf, wr_ovf, wr_en;
  logic [CNT_W-1:0]  rd_cnt, wr_cnt;
  ptr_vec_t          rd_ptrs, wr_ptrs;
  logic              hit;
  logic [SLOTS-1:0]  others_mask;

  // Transaction registers
  eng_state_e        eng_q, eng_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [NODE_W-1:0] node_q, node_d;
  logic              write_q, write_d, fetch_q, fetch_d;
  ptr_vec_t          wk_q, wk_d, ptrs_v;
  logic [SLOTS-1:0]  mask_q, mask_d, pick_onehot;
  logic [CNT_W-1:0]  pend_q, pend_d;
  logic [SEL_W-1:0]  pick_idx;
  logic              rsp_valid_d, rsp_excl_d, nack_valid_d;
  logic [NODE_W-1:0] rsp_node_d, nack_node_d;

  dir_entry_store #(
    .NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W), .NODE_W(NODE_W),
    .SLOTS(SLOTS), .CNT_W(CNT_W), .NUM_PTRS(NUM_PTRS)
  ) u_store (
    .clk(clk), .rst_n(rst_sync_n),
    .rd_addr(rd_addr), .rd_state(rd_state), .rd_ovf(rd_ovf),
    .rd_cnt(rd_cnt), .rd_ptrs(rd_ptrs),
    .wr_en(wr_en), .wr_addr(addr_d), .wr_state(wr_state),
    .wr_ovf(wr_ovf), .wr_cnt(wr_cnt), .wr_ptrs(wr_ptrs)
  );

  dir_sharer_match #(.NODE_W(NODE_W), .SLOTS(SLOTS), .CNT_W(CNT_W)) u_match (
    .ptrs(rd_ptrs), .cnt(rd_cnt), .node(req_node),
    .hit(hit), .others_mask(others_mask)
  );

  assign rd_addr = (eng_q == ENG_IDLE) ? req_addr : addr_q;

  // Lowest pending invalidation target
  always_comb begin
    pick_idx = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (mask_q[s]) pick_idx = SEL_W'(s);
    end
    pick_onehot = SLOTS'(1) << pick_idx;
  end

  // Next-state logic
  always_comb begin
    eng_d        = eng_q;
    addr_d       = addr_q;
    node_d       = node_q;
    write_d      = write_q;
    fetch_d      = fetch_q;
    wk_d         = wk_q;
    mask_d       = mask_q;
    pend_d       = pend_q + CNT_W'(eng_q == ENG_SEND) - CNT_W'(ack_valid);
    rsp_valid_d  = 1'b0;
    rsp_excl_d   = rsp_excl;
    rsp_node_d   = rsp_node;
    nack_valid_d = 1'b0;
    nack_node_d  = nack_node;
    ptrs_v       = rd_ptrs;
    wr_en        = 1'b0;
    wr_state     = rd_state;
    wr_ovf       = rd_ovf;
    wr_cnt       = rd_cnt;
    wr_ptrs      = rd_ptrs;

    if (req_valid && eng_q != ENG_IDLE) begin
      nack_valid_d = 1'b1;
      nack_node_d  = req_node;
    end

    case (eng_q)
      ENG_IDLE: begin
        if (req_valid) begin
          addr_d     = req_addr;
          node_d     = req_node;
          write_d    = req_write;
          rsp_node_d = req_node;
          if (ZERO_MODE || rd_ovf) begin
            eng_d = ENG_TRAP;
          end else if ((rd_state == BLK_WD) && !hit) begin
            wk_d    = rd_ptrs;
            mask_d  = SLOTS'(1);
            fetch_d = 1'b1;
            eng_d   = ENG_SEND;
          end else if (rd_state == BLK_WD) begin
            rsp_valid_d = 1'b1;
            rsp_excl_d  = 1'b1;
          end else if (req_write && rd_state == BLK_RC && others_mask != '0) begin
            wk_d    = rd_ptrs;
            mask_d  = others_mask;
            fetch_d = 1'b0;
            eng_d   = ENG_SEND;
          end else if (req_write) begin
            ptrs_v[0]   = req_node;
            wr_en       = 1'b1;
            wr_state    = BLK_WD;
            wr_cnt      = CNT_W'(1);
            wr_ptrs     = ptrs_v;
            rsp_valid_d = 1'b1;
            rsp_excl_d  = 1'b1;
          end else if (rd_state == BLK_INV) begin
            ptrs_v[0]   = req_node;
            wr_en       = 1'b1;
            wr_state    = BLK_RC;
            wr_cnt      = CNT_W'(1);
            wr_ptrs     = ptrs_v;
            rsp_valid_d = 1'b1;
            rsp_excl_d  = 1'b0;
          end else if (hit) begin
            rsp_valid_d = 1'b1;
            rsp_excl_d  = 1'b0;
          end else if (rd_cnt < CNT_W'(SLOTS)) begin
            ptrs_v[rd_cnt[SEL_W-1:0]] = req_node;
            wr_en       = 1'b1;
            wr_cnt      = rd_cnt + CNT_W'(1);
            wr_ptrs     = ptrs_v;
            rsp_valid_d = 1'b1;
            rsp_excl_d  = 1'b0;
          end else begin
            wr_en  = 1'b1;
            wr_ovf = 1'b1;
            eng_d  = ENG_TRAP;
          end
        end
      end
      ENG_SEND: begin
        mask_d = mask_q & ~pick_onehot;
        if (mask_d == '0) eng_d = ENG_WAIT;
      end
      ENG_WAIT: begin
        if (pend_d == '0) begin
          wr_en = 1'b1;
          if (write_q) begin
            ptrs_v[0] = node_q;
            wr_state  = BLK_WD;
            wr_cnt    = CNT_W'(1);
          end else begin
            ptrs_v[0] = wk_q[0];
            ptrs_v[1] = node_q;
            wr_state  = BLK_RC;
            wr_cnt    = CNT_W'(2);
          end
          wr_ptrs     = ptrs_v;
          rsp_valid_d = 1'b1;
          rsp_excl_d  = write_q;
          rsp_node_d  = node_q;
          eng_d       = ENG_IDLE;
        end
      end
      default: begin
        if (trap_done) begin
          eng_d = ENG_IDLE;
          if (trap_release) begin
            wr_en    = 1'b1;
            wr_state = BLK_INV;
            wr_ovf   = 1'b0;
            wr_cnt   = '0;
          end
        end
      end
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      eng_q      <= ENG_IDLE;
      addr_q     <= '0;
      node_q     <= '0;
      write_q    <= 1'b0;
      fetch_q    <= 1'b0;
      wk_q       <= '0;
      mask_q     <= '0;
      pend_q     <= '0;
      rsp_valid  <= 1'b0;
      rsp_excl   <= 1'b0;
      rsp_node   <= '0;
      nack_valid <= 1'b0;
      nack_node  <= '0;
    end else begin
      eng_q      <= eng_d;
      addr_q     <= addr_d;
      node_q     <= node_d;
      write_q    <= write_d;
      fetch_q    <= fetch_d;
      wk_q       <= wk_d;
      mask_q     <= mask_d;
      pend_q     <= pend_d;
      rsp_valid  <= rsp_valid_d;
      rsp_excl   <= rsp_excl_d;
      rsp_node   <= rsp_node_d;
      nack_valid <= nack_valid_d;
      nack_node  <= nack_node_d;
    end
  end

  assign inv_valid  = (eng_q == ENG_SEND);
  assign inv_fetch  = fetch_q;
  assign inv_addr   = addr_q;
  assign inv_node   = wk_q[pick_idx];
  assign trap_valid = (eng_q == ENG_TRAP);
  assign trap_write = write_q;
  assign trap_addr  = addr_q;
  assign trap_node  = node_q;

  // Trap fields stay put until the handler finishes.
  assert_trap_stable_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (trap_valid && !trap_done) |=> (trap_valid && $stable({trap_addr, trap_node, trap_write})))
    else $error("trap fields moved before done");

  // No grant while acknowledgements are outstanding and none arrives.
  assert_grant_after_acks_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (eng_q == ENG_WAIT && pend_q > CNT_W'(1)) |=> !rsp_valid)
    else $error("exclusive grant before all acknowledgements");

  // Acknowledgements only come for invalidations already issued.
  assert_ack_expected_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ack_valid |-> (pend_q != '0 || inv_valid))
    else $error("acknowledgement with nothing outstanding");

  // Grants, invalidations and traps never overlap.
  assert_one_action_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({rsp_valid, inv_valid, trap_valid}))
    else $error("more than one outbound action");

  // A request while busy is told to retry.
  assert_busy_retry_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && eng_q != ENG_IDLE) |=> (nack_valid && nack_node == $past(req_node)))
    else $error("busy request not refused");

  // An entry carrying the overflow mark always traps.
  assert_ovf_traps_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && eng_q == ENG_IDLE && rd_ovf) |=> trap_valid)
    else $error("overflowed entry handled in hardware");

  if (ZERO_MODE) begin : g_zero_chk
    assert_zero_traps_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (req_valid && eng_q == ENG_IDLE) |=> (trap_valid && !rsp_valid))
      else $error("zero-slot directory did not trap");
  end
endmodule

// File: tb/dir_home_ctrl_tb.sv
module dir_home_ctrl_tb;
  localparam int NB = 8;
  localparam int NW = 3;
  localparam int AW = 3;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          req_valid = 0, req_write = 0, ack_valid = 0, trap_done = 0, trap_release = 0;
  logic [AW-1:0] req_addr = '0;
  logic [NW-1:0] req_node = '0;
  logic          rsp_valid, rsp_excl, nack_valid, inv_valid, inv_fetch, trap_valid, trap_write;
  logic [NW-1:0] rsp_node, nack_node, inv_node, trap_node;
  logic [AW-1:0] inv_addr, trap_addr;

  logic          z_req_valid = 0, z_req_write = 0, z_trap_done = 0, z_trap_release = 0;
  logic [AW-1:0] z_req_addr = '0;
  logic [NW-1:0] z_req_node = '0;
  logic          z_rsp_valid, z_rsp_excl, z_nack_valid, z_inv_valid, z_inv_fetch, z_trap_valid, z_trap_write;
  logic [NW-1:0] z_rsp_node, z_nack_node, z_inv_node, z_trap_node;
  logic [AW-1:0] z_inv_addr, z_trap_addr;

  dir_home_ctrl #(.NUM_BLOCKS(NB), .NODE_W(NW), .NUM_PTRS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_node(req_node), .rsp_valid(rsp_valid),
    .rsp_excl(rsp_excl), .rsp_node(rsp_node), .nack_valid(nack_valid),
    .nack_node(nack_node), .inv_valid(inv_valid), .inv_fetch(inv_fetch),
    .inv_addr(inv_addr), .inv_node(inv_node), .ack_valid(ack_valid),
    .trap_valid(trap_valid), .trap_write(trap_write), .trap_addr(trap_addr),
    .trap_node(trap_node), .trap_done(trap_done), .trap_release(trap_release));

  dir_home_ctrl #(.NUM_BLOCKS(NB), .NODE_W(NW), .NUM_PTRS(0)) u_dut_zero (
    .clk(clk), .rst_n(rst_n), .req_valid(z_req_valid), .req_write(z_req_write),
    .req_addr(z_req_addr), .req_node(z_req_node), .rsp_valid(z_rsp_valid),
    .rsp_excl(z_rsp_excl), .rsp_node(z_rsp_node), .nack_valid(z_nack_valid),
    .nack_node(z_nack_node), .inv_valid(z_inv_valid), .inv_fetch(z_inv_fetch),
    .inv_addr(z_inv_addr), .inv_node(z_inv_node), .ack_valid(1'b0),
    .trap_valid(z_trap_valid), .trap_write(z_trap_write), .trap_addr(z_trap_addr),
    .trap_node(z_trap_node), .trap_done(z_trap_done), .trap_release(z_trap_release));

  int n_checks = 0;
  int n_fail   = 0;
  bit done_run = 0;

  // Reference directory: state 0 invalid, 1 read-clean, 2 write-dirty
  int m_state [NB];
  bit m_ovf   [NB];
  int m_cnt   [NB];
  int m_sh    [NB][NP];

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_run) begin
      done_run = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  function automatic bit m_has(input int a, input int n);
    for (int i = 0; i < m_cnt[a]; i++) if (m_sh[a][i] == n) return 1;
    return 0;
  endfunction

  task automatic probe_busy(input int pn, input string tag);
    req_valid = 1; req_write = 0; req_addr = AW'(pn % NB); req_node = NW'(pn);
    @(negedge clk);
    req_valid = 0;
    check(nack_valid == 1, tag, "retry pulse while busy (R8)", int'(nack_valid), 1);
    check(int'(nack_node) == pn, tag, "retry node (R8)", int'(nack_node), pn);
  endtask

  task automatic do_req(input int n, input int a, input bit w, input bit rel, input bit probe);
    int kind = 0;            // 0 immediate grant, 1 invalidations, 2 trap
    bit exp_excl = 0;
    bit exp_fetch = 0;
    int exp_inv[NP];
    int n_inv = 0;
    string tag = "R2";
    bit had = m_has(a, n);
    if (m_ovf[a]) begin
      kind = 2; tag = "R4";
    end else if (!w) begin
      if (m_state[a] == 0) begin kind = 0; tag = "R2"; end
      else if (m_state[a] == 1) begin
        if (had) begin kind = 0; tag = "R9"; end
        else if (m_cnt[a] < NP) begin kind = 0; tag = "R2"; end
        else begin kind = 2; tag = "R3"; end
      end else begin
        if (m_sh[a][0] == n) begin kind = 0; exp_excl = 1; tag = "R9"; end
        else begin kind = 1; exp_fetch = 1; exp_inv[0] = m_sh[a][0]; n_inv = 1; tag = "R7"; end
      end
    end else begin
      exp_excl = 1;
      if (m_state[a] == 0) begin kind = 0; tag = "R9"; end
      else if (m_state[a] == 1) begin
        for (int i = 0; i < m_cnt[a]; i++)
          if (m_sh[a][i] != n) begin exp_inv[n_inv] = m_sh[a][i]; n_inv++; end
        kind = (n_inv == 0) ? 0 : 1;
        tag  = (n_inv == 0) ? "R9" : "R6";
      end else begin
        if (m_sh[a][0] == n) begin kind = 0; tag = "R9"; end
        else begin kind = 1; exp_fetch = 1; exp_inv[0] = m_sh[a][0]; n_inv = 1; tag = "R7"; end
      end
    end

    req_valid = 1; req_write = w; req_addr = AW'(a); req_node = NW'(n);
    @(negedge clk);
    req_valid = 0;

    if (kind == 0) begin
      check(rsp_valid == 1, tag, "grant present", int'(rsp_valid), 1);
      check(rsp_excl == exp_excl, tag, "grant kind", int'(rsp_excl), int'(exp_excl));
      check(int'(rsp_node) == n, tag, "grant node", int'(rsp_node), n);
      check(inv_valid == 0 && trap_valid == 0, tag, "no side action", int'({inv_valid, trap_valid}), 0);
    end else if (kind == 1) begin
      for (int i = 0; i < n_inv; i++) begin
        check(inv_valid == 1, tag, "invalidation present", int'(inv_valid), 1);
        check(int'(inv_node) == exp_inv[i], tag, "invalidation target", int'(inv_node), exp_inv[i]);
        check(inv_fetch == exp_fetch, tag, "recall flag", int'(inv_fetch), int'(exp_fetch));
        check(int'(inv_addr) == a, tag, "invalidation block", int'(inv_addr), a);
        @(negedge clk);
      end
      check(inv_valid == 0, tag, "invalidation count", int'(inv_valid), 0);
      check(rsp_valid == 0, tag, "no grant before acks", int'(rsp_valid), 0);
      if (probe) probe_busy((n + 3) % 8, tag);
      for (int i = 0; i < n_inv; i++) begin
        ack_valid = 1;
        @(negedge clk);
        ack_valid = 0;
        if (i < n_inv - 1)
          check(rsp_valid == 0, tag, "grant held for acks", int'(rsp_valid), 0);
      end
      check(rsp_valid == 1, tag, "grant after last ack", int'(rsp_valid), 1);
      check(rsp_excl == w, tag, "grant kind after acks", int'(rsp_excl), int'(w));
      check(int'(rsp_node) == n, tag, "grant node after acks", int'(rsp_node), n);
    end else begin
      for (int c = 0; c < 3; c++) begin
        check(trap_valid == 1, tag, "trap raised", int'(trap_valid), 1);
        check(int'(trap_addr) == a, tag, "trap block", int'(trap_addr), a);
        check(int'(trap_node) == n, tag, "trap node", int'(trap_node), n);
        check(trap_write == w, tag, "trap type", int'(trap_write), int'(w));
        check(rsp_valid == 0, tag, "no grant on trap", int'(rsp_valid), 0);
        if (probe && c == 0) probe_busy((n + 5) % 8, tag);
        else @(negedge clk);
      end
      trap_done = 1; trap_release = rel;
      @(negedge clk);
      trap_done = 0; trap_release = 0;
      check(trap_valid == 0, tag, "trap cleared by done", int'(trap_valid), 0);
    end

    // Reference update
    if (kind == 0) begin
      if (w) begin m_state[a] = 2; m_cnt[a] = 1; m_sh[a][0] = n; end
      else if (m_state[a] == 0) begin m_state[a] = 1; m_cnt[a] = 1; m_sh[a][0] = n; end
      else if (m_state[a] == 1 && !had) begin m_sh[a][m_cnt[a]] = n; m_cnt[a]++; end
    end else if (kind == 1) begin
      if (w) begin m_state[a] = 2; m_cnt[a] = 1; m_sh[a][0] = n; end
      else begin m_state[a] = 1; m_cnt[a] = 2; m_sh[a][1] = n; end
    end else begin
      if (rel) begin m_state[a] = 0; m_cnt[a] = 0; m_ovf[a] = 0; end
      else m_ovf[a] = 1;
    end
  endtask

  task automatic zero_req(input int n, input int a, input bit w);
    z_req_valid = 1; z_req_write = w; z_req_addr = AW'(a); z_req_node = NW'(n);
    @(negedge clk);
    z_req_valid = 0;
    check(z_trap_valid == 1, "R5", "zero-slot trap", int'(z_trap_valid), 1);
    check(z_rsp_valid == 0, "R5", "zero-slot no grant", int'(z_rsp_valid), 0);
    check(int'(z_trap_node) == n && z_trap_write == w, "R5", "zero-slot trap fields",
          int'(z_trap_node), n);
    z_trap_done = 1; z_trap_release = 1;
    @(negedge clk);
    z_trap_done = 0; z_trap_release = 0;
    check(z_trap_valid == 0 && z_rsp_valid == 0, "R5", "zero-slot after done", int'(z_trap_valid), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : stim
    int seed_sink;
    seed_sink = $urandom(32'h5eed_0d1c);
    for (int b = 0; b < NB; b++) begin m_state[b] = 0; m_ovf[b] = 0; m_cnt[b] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: quiet outputs after reset
    check(rsp_valid == 0 && nack_valid == 0, "R1", "reset grant/retry", int'({rsp_valid, nack_valid}), 0);
    check(inv_valid == 0 && trap_valid == 0, "R1", "reset inval/trap", int'({inv_valid, trap_valid}), 0);
    check(z_trap_valid == 0, "R1", "reset zero-slot trap", int'(z_trap_valid), 0);

    // R1/R9: block 2 starts invalid, so a write is granted at once
    do_req(3, 2, 1, 0, 0);

    // R2 fill to capacity; R9 repeat reader; R3 fifth reader traps; R10 no release
    do_req(1, 5, 0, 0, 0);
    do_req(2, 5, 0, 0, 0);
    do_req(3, 5, 0, 0, 0);
    do_req(2, 5, 0, 0, 0);
    do_req(4, 5, 0, 0, 0);
    do_req(2, 5, 0, 0, 0);
    do_req(6, 5, 0, 0, 1);
    do_req(1, 5, 0, 0, 0);
    do_req(1, 5, 1, 1, 0);
    do_req(7, 5, 1, 0, 0);

    // R6: writer among sharers, others invalidated in slot order, retry probe
    do_req(0, 6, 0, 0, 0);
    do_req(1, 6, 0, 0, 0);
    do_req(2, 6, 0, 0, 0);
    do_req(1, 6, 1, 0, 1);

    // R7: recall from dirty owner, then a write proves both were recorded
    do_req(3, 7, 1, 0, 0);
    do_req(4, 7, 0, 0, 1);
    do_req(5, 7, 1, 0, 0);
    do_req(6, 7, 1, 0, 0);

    // R5: zero-slot instance traps reads and writes
    zero_req(2, 1, 0);
    zero_req(2, 1, 1);
    zero_req(5, 4, 0);

    // Constrained random mix on a few blocks to reach overflow often
    for (int t = 0; t < 500; t++) begin
      int n = int'($urandom % 8);
      int a = int'($urandom % 3);
      bit w = ($urandom % 4) == 0;
      bit r = ($urandom % 2) == 0;
      bit p = ($urandom % 5) == 0;
      do_req(n, a, w, r, p);
    end

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule